// File: doc/BRIEF.md
# Timestamp Queuing FIFO Arbiter

This block shares one resource among a fixed number of requesters and serves them in order of arrival. When a request line rises, the block records the value of a free-running time counter against that requester. Each cycle, the block compares the ages of all asserted requests in a binary tree. It grants the oldest one on a one-hot grant vector in the same cycle. A request that arrives in the current cycle competes with age zero.

A granted requester loses its stamp. If it keeps its line high, it queues again as a fresh arrival in the next cycle. A requester that lowers its line before it is served also loses its stamp and its place. Ages are computed by modular subtraction from the current time, so the order stays correct when the counter rolls over. The stamp width is the main cost knob: it sets the width of every stamp register and every tree comparator. The configuration constants live in the shared package: requester count `REQ_N`, default 4, and stamp width `STAMP_W`, default 4.

Top module: `fifo_arb_top`

## Requirements
- R1: After reset no requester holds a stamp, and the grant vector is zero while no request is asserted.
- R2: The grant vector has at most one bit set, and it is nonzero in every cycle in which at least one request bit is set. Bit k of both vectors belongs to requester k.
- R3: A grant bit is set only for a requester whose request bit is set in the same cycle.
- R4: Among the asserted requests, the grant goes to the one whose request has been high longest since its last grant or drop.
- R5: Requests with equal age are served lowest index first.
- R6: A request asserted in a cycle with no competitor is granted in that same cycle.
- R7: A requester granted in a cycle that still asserts its request in the next cycle counts as a new arrival in that next cycle.
- R8: A request that is lowered before it is granted loses its stamp; if raised again it queues behind requests already waiting.
- R9: The order of R4 stays correct across rollover of the STAMP_W-bit time counter.
- R10: With one grant per cycle, every stamped request has an age below REQ_N cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| reqVec | input | REQ_N | Request lines, bit k for requester k |
| grantVec | output | REQ_N | One-hot grant, combinational from reqVec and stored stamps |

## Verification
The assertions compare ages of stamped requests, so they rely on every wait staying under half the time counter range. That bound is implied by R10 whenever REQ_N is at most 2^(STAMP_W-1), and the 4-requester, 4-bit default configuration is chosen to satisfy it. The assertions do not need requesters to hold their lines. The stimulus mostly holds pending lines until grant and drops a pending line once every seven cycles, without re-raising it in the same cycle, so that the stamp-clear path is exercised as well. The sweep runs for thousands of cycles, which wraps the time counter many times while arrival patterns cycle through all request masks.

// File: rtl/fifo_arb_pkg.sv
package fifo_arb_pkg;
  parameter int REQ_N   = 4;
  parameter int STAMP_W = 4;
  localparam int IDX_W  = (REQ_N > 1) ? $clog2(REQ_N) : 1;

  // strobes from control to datapath
  typedef struct packed {
    logic [REQ_N-1:0] loadMask;  // capture current time for these requesters
    logic [REQ_N-1:0] dropMask;  // these stamps are retired this cycle
  } arbStrobe_t;
endpackage

// File: rtl/fifo_arb_ctrl.sv
module fifo_arb_ctrl
  import fifo_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [REQ_N-1:0] reqVec,
  input  logic [REQ_N-1:0] grantVec,
  output arbStrobe_t       strobe,
  output logic [REQ_N-1:0] stampVld
);
  // new arrival: request high, no stamp yet, and not served this very cycle
  always_comb begin
    strobe.loadMask = reqVec & ~stampVld & ~grantVec;
    strobe.dropMask = stampVld & (grantVec | ~reqVec);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stampVld <= '0;
    else       stampVld <= (stampVld & ~strobe.dropMask) | strobe.loadMask;
  end
endmodule

// File: rtl/fifo_arb_dpath.sv
module fifo_arb_dpath
  import fifo_arb_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [REQ_N-1:0]         reqVec,
  input  logic [REQ_N-1:0]         stampVld,
  input  arbStrobe_t               strobe,
  output logic [REQ_N-1:0]         grantVec,
  output logic [REQ_N*STAMP_W-1:0] ageFlat
);
  localparam int LEAF_N = 1 << $clog2(REQ_N);
  localparam int NODE_N = 2 * LEAF_N - 1;

  logic [STAMP_W-1:0] nowTime;
  logic [STAMP_W-1:0] stampReg [REQ_N];
  logic [STAMP_W-1:0] ageVal   [REQ_N];

  logic               nodeVld [NODE_N];
  logic [STAMP_W-1:0] nodeAge [NODE_N];
  logic [IDX_W-1:0]   nodeIdx [NODE_N];

  // free-running time base, allowed to wrap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nowTime <= '0;
    else       nowTime <= nowTime + 1'b1;
  end

  for (genvar i = 0; i < REQ_N; i++) begin : g_stamp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   stampReg[i] <= '0;
      else if (strobe.loadMask[i]) stampReg[i] <= nowTime;
      else if (strobe.dropMask[i]) stampReg[i] <= '0;
    end
    // modular age: an unstamped request is a fresh arrival with age zero
    assign ageVal[i] = stampVld[i] ? (nowTime - stampReg[i]) : '0;
    assign ageFlat[i*STAMP_W +: STAMP_W] = ageVal[i];
  end

  // leaves of the comparator tree, padded to a power of two
  for (genvar j = 0; j < LEAF_N; j++) begin : g_leaf
    if (j < REQ_N) begin : g_real
      assign nodeVld[LEAF_N-1+j] = reqVec[j];
      assign nodeAge[LEAF_N-1+j] = ageVal[j];
      assign nodeIdx[LEAF_N-1+j] = IDX_W'(j);
    end else begin : g_pad
      assign nodeVld[LEAF_N-1+j] = 1'b0;
      assign nodeAge[LEAF_N-1+j] = '0;
      assign nodeIdx[LEAF_N-1+j] = '0;
    end
  end

  // internal nodes: the left child holds lower indices and wins ties
  for (genvar k = 0; k < LEAF_N - 1; k++) begin : g_node
    logic pickLeft;
    assign pickLeft = nodeVld[2*k+1] &&
                      (!nodeVld[2*k+2] || (nodeAge[2*k+1] >= nodeAge[2*k+2]));
    assign nodeVld[k] = nodeVld[2*k+1] | nodeVld[2*k+2];
    assign nodeAge[k] = pickLeft ? nodeAge[2*k+1] : nodeAge[2*k+2];
    assign nodeIdx[k] = pickLeft ? nodeIdx[2*k+1] : nodeIdx[2*k+2];
  end

  always_comb begin
    grantVec = '0;
    if (nodeVld[0]) grantVec[nodeIdx[0]] = 1'b1;
  end
endmodule

// File: rtl/fifo_arb_top.sv
module fifo_arb_top
  import fifo_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [REQ_N-1:0] reqVec,
  output logic [REQ_N-1:0] grantVec
);
  arbStrobe_t               strobe;
  logic [REQ_N-1:0]         stampVld;
  logic [REQ_N*STAMP_W-1:0] ageFlat;

  fifo_arb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqVec   (reqVec),
    .grantVec (grantVec),
    .strobe   (strobe),
    .stampVld (stampVld)
  );

  fifo_arb_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .reqVec   (reqVec),
    .stampVld (stampVld),
    .strobe   (strobe),
    .grantVec (grantVec),
    .ageFlat  (ageFlat)
  );
endmodule

// File: rtl/fifo_arb_checker.sv
module fifo_arb_checker
  import fifo_arb_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic [REQ_N-1:0]         reqVec,
  input logic [REQ_N-1:0]         grantVec,
  input logic [REQ_N-1:0]         stampVld,
  input logic [REQ_N*STAMP_W-1:0] ageFlat
);
  logic [STAMP_W-1:0] winAge;
  int                 winIdx;

  always_comb begin
    winAge = '0;
    winIdx = 0;
    for (int k = 0; k < REQ_N; k++) begin
      if (grantVec[k]) begin
        winAge = ageFlat[k*STAMP_W +: STAMP_W];
        winIdx = k;
      end
    end
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec));
  a_r2_busy_grants: assert property (@(posedge clk) disable iff (!rstN)
    (|reqVec) |-> (|grantVec));
  a_r3_grant_in_req: assert property (@(posedge clk) disable iff (!rstN)
    (grantVec & ~reqVec) == '0);

  for (genvar j = 0; j < REQ_N; j++) begin : g_chk
    a_r4_oldest_wins: assert property (@(posedge clk) disable iff (!rstN)
      (reqVec[j] && (|grantVec)) |-> (ageFlat[j*STAMP_W +: STAMP_W] <= winAge));
    a_r5_tie_low_index: assert property (@(posedge clk) disable iff (!rstN)
      (reqVec[j] && (|grantVec) && (ageFlat[j*STAMP_W +: STAMP_W] == winAge))
        |-> (j >= winIdx));
    a_r4_wait_keeps_stamp: assert property (@(posedge clk) disable iff (!rstN)
      (reqVec[j] && !grantVec[j]) |=> stampVld[j]);
    a_r7_clear_on_grant: assert property (@(posedge clk) disable iff (!rstN)
      grantVec[j] |=> !stampVld[j]);
    a_r8_clear_on_drop: assert property (@(posedge clk) disable iff (!rstN)
      !reqVec[j] |=> !stampVld[j]);
    a_r10_age_bound: assert property (@(posedge clk) disable iff (!rstN)
      stampVld[j] |-> (int'(ageFlat[j*STAMP_W +: STAMP_W]) < REQ_N));
  end
endmodule

bind fifo_arb_top fifo_arb_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqVec   (reqVec),
  .grantVec (grantVec),
  .stampVld (stampVld),
  .ageFlat  (ageFlat)
);

// File: tb/fifo_arb_top_bench.sv
`timescale 1ns/1ps
module fifo_arb_top_bench;
  localparam int N = fifo_arb_pkg::REQ_N;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] reqVec = '0;
  logic [N-1:0] grantVec;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  // reference model state
  bit pend [N];
  int arr  [N];
  int cyc  = 0;

  always #2.5 clk = ~clk;

  fifo_arb_top u_fifo_arb_top (
    .clk      (clk),
    .rstN     (rstN),
    .reqVec   (reqVec),
    .grantVec (grantVec)
  );

  task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %b expected %b (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  // one arbitration cycle; useLit selects a literal expectation over the model
  task automatic runCycle(input logic [N-1:0] addM, input logic [N-1:0] dropM,
                          input logic [N-1:0] expLit, input bit useLit, input string tag);
    logic [N-1:0] req;
    logic [N-1:0] expG;
    int best;
    int bestArr;
    @(negedge clk);
    for (int i = 0; i < N; i++) req[i] = (pend[i] && !dropM[i]) || addM[i];
    reqVec = req;
    best = -1;
    bestArr = 0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        int eff;
        eff = pend[i] ? arr[i] : cyc;
        if (best < 0 || eff < bestArr) begin
          best = i;
          bestArr = eff;
        end
      end
    end
    expG = '0;
    if (best >= 0) expG[best] = 1'b1;
    if (useLit) expG = expLit;
    #1;
    check(tag, grantVec, expG);
    // R2 and R3 structural checks
    check("R2 one-hot", {{(N-1){1'b0}}, ($countones(grantVec) == ((req != '0) ? 1 : 0))},
          {{(N-1){1'b0}}, 1'b1});
    check("R3 grant within request", grantVec & ~req, '0);
    if (best >= 0 && pend[best]) begin
      check("R10 wait bound", {{(N-1){1'b0}}, ((cyc - arr[best]) < N)}, {{(N-1){1'b0}}, 1'b1});
    end
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (expG[i] || !req[i]) pend[i] = 0;
      else if (!pend[i]) begin
        pend[i] = 1;
        arr[i] = cyc;
      end
    end
    cyc++;
  endtask

  task automatic drain();
    for (int k = 0; k < N + 1; k++) runCycle('0, '0, '0, 0, "drain");
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      pend[i] = 0;
      arr[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: idle after reset
    runCycle('0, '0, '0, 1, "R1 idle after reset");
    runCycle('0, '0, '0, 1, "R1 idle after reset");

    // R6: lone request served in its own cycle
    runCycle(4'b0100, '0, 4'b0100, 1, "R6 lone request");
    drain();

    // R5: simultaneous arrivals served by index
    runCycle(4'b1111, '0, 4'b0001, 1, "R5 tie index 0");
    runCycle('0, '0, 4'b0010, 1, "R5 tie index 1");
    runCycle('0, '0, 4'b0100, 1, "R5 tie index 2");
    runCycle('0, '0, 4'b1000, 1, "R5 tie index 3");
    drain();

    // R4: older high-index request beats newer low-index one
    runCycle(4'b0110, '0, 4'b0010, 1, "R4 first pair");
    runCycle(4'b0001, '0, 4'b0100, 1, "R4 older wins");
    runCycle('0, '0, 4'b0001, 1, "R4 newer served");
    drain();

    // R7: re-request after grant queues behind a waiter
    runCycle(4'b0011, '0, 4'b0001, 1, "R7 first grant");
    runCycle(4'b0001, '0, 4'b0010, 1, "R7 waiter first");
    runCycle('0, '0, 4'b0001, 1, "R7 re-request served");
    drain();

    // R8: dropped request loses its place
    runCycle(4'b0111, '0, 4'b0001, 1, "R8 setup");
    runCycle(4'b1000, 4'b0010, 4'b0100, 1, "R8 drop one waiter");
    runCycle(4'b0010, '0, 4'b1000, 1, "R8 older stays ahead");
    runCycle('0, '0, 4'b0010, 1, "R8 re-raised served last");
    drain();

    // R4 / R9: long sweep over arrival masks, wrapping the time counter
    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] addM;
      logic [N-1:0] dropM;
      addM = N'((c * 5 + c / 16 + 3) % (1 << N));
      if (c % 3 == 0) addM = '0;
      dropM = '0;
      if (c % 7 == 3) dropM[(c / 7) % N] = 1'b1;
      addM = addM & ~dropM;
      runCycle(addM, dropM, '0, 0, "R4 R9 sweep order");
    end
    drain();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end
endmodule